// File: doc/BRIEF.md
# SMI Feature Negotiation Controller

This block runs a one-shot handshake in which firmware asks for a subset of the system-management-interrupt features that the host offers. The host offer is a fixed 64-bit mask set by a parameter. Firmware fills a 64-bit request word one byte lane at a time, in little-endian order. It then pulses a validation strobe, which stands for a write to the acceptance byte. If the request asks only for offered bits, it is copied into a negotiated register and the acceptance flag sets. From then on, both stay frozen until reset.

The block also decodes writes to the 8-bit power-management command port. Two parameter codes, ACPI enable and ACPI disable, each produce a one-cycle control pulse and no SMI. Any other code produces an SMI only when the command-SMI enable input is high. If negotiated bit 0 (the broadcast feature) is set, the SMI reaches every CPU. Otherwise it reaches only the CPU named as the writer of the command.

Top module: `smi_negotiator`

## Requirements
- R1: While reset is low and after it is released, the request word, acceptance flag and negotiated word read zero, and the SMI and ACPI pulse outputs are zero.
- R2: A request write with byte strobe k high loads bits 8k+7..8k of the request word from the same bits of the write data. Lanes whose strobe is low keep their value (byte 0 is the least significant byte).
- R3: A validation strobe seen while the flag is 0 and the stored request has no bit outside the host mask sets the flag and copies the request into the negotiated word on that clock edge. A request written in the same cycle as the strobe is not yet part of the stored value.
- R4: A validation strobe with any request bit outside the host mask leaves the flag at 0 and the negotiated word unchanged.
- R5: Once the flag is 1, later validation strobes and request writes leave the flag and the negotiated word unchanged until reset.
- R6: A command write equal to CMD_ACPI_ON gives a one-cycle pulse on acpi_on_pulse in the next cycle, and no SMI.
- R7: A command write equal to CMD_ACPI_OFF gives a one-cycle pulse on acpi_off_pulse in the next cycle, and no SMI.
- R8: Any other command write gives no SMI while smi_cmd_en is low.
- R9: Any other command write with smi_cmd_en high and negotiated bit 0 set drives all bits of smi_pulse high for one cycle, in the next cycle.
- R10: Any other command write with smi_cmd_en high and negotiated bit 0 clear drives only bit cmd_cpu of smi_pulse high for one cycle, in the next cycle.
- R11: host_mask always equals the HOST_MASK parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_wr | input | 1 | Request word write strobe |
| req_be | input | 8 | Byte-lane enables for the request write |
| req_wdata | input | 64 | Request write data |
| ok_wr | input | 1 | Acceptance-byte write; starts validation |
| cmd_wr | input | 1 | Command port write strobe |
| cmd_code | input | 8 | Command byte written |
| cmd_cpu | input | CW | Index of the CPU issuing the command write |
| smi_cmd_en | input | 1 | Command-SMI enable bit |
| host_mask | output | 64 | Host-offered feature mask |
| req_word | output | 64 | Stored request word |
| ok_flag | output | 1 | Acceptance flag |
| neg_feat | output | 64 | Negotiated features |
| acpi_on_pulse | output | 1 | ACPI enable pulse |
| acpi_off_pulse | output | 1 | ACPI disable pulse |
| smi_pulse | output | NCPU | Per-CPU SMI pulse |

## Verification
The bench builds the block with four CPUs, the default command codes, and a host mask of 0x8000_0000_0000_0011. That mask offers the broadcast bit, bit 4 and bit 63, and leaves the bits in between unoffered. The rejected case is therefore a request with bits above the low byte. The non-broadcast case is a request of bit 4 alone. The broadcast case is a request for all three offered bits, negotiated after a mid-run reset. With four CPUs, single-CPU SMIs can be checked at the lowest, a middle and the highest index against an all-ones vector.

// File: rtl/smi_negotiator.sv
module smi_negotiator #(
  parameter int          NCPU         = 4,
  parameter logic [63:0] HOST_MASK    = 64'h1,
  parameter logic [7:0]  CMD_ACPI_ON  = 8'h02,
  parameter logic [7:0]  CMD_ACPI_OFF = 8'h03,
  localparam int         CW           = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_wr,
  input  logic [7:0]      req_be,
  input  logic [63:0]     req_wdata,
  input  logic            ok_wr,
  input  logic            cmd_wr,
  input  logic [7:0]      cmd_code,
  input  logic [CW-1:0]   cmd_cpu,
  input  logic            smi_cmd_en,
  output logic [63:0]     host_mask,
  output logic [63:0]     req_word,
  output logic            ok_flag,
  output logic [63:0]     neg_feat,
  output logic            acpi_on_pulse,
  output logic            acpi_off_pulse,
  output logic [NCPU-1:0] smi_pulse
);

  localparam logic [NCPU-1:0] ONE = {{(NCPU-1){1'b0}}, 1'b1};

  logic [63:0]     req_q;
  logic [63:0]     neg_q;
  logic            ok_q;
  logic            on_q, off_q;
  logic [NCPU-1:0] smi_q;

  for (genvar k = 0; k < 8; k++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                  req_q[8*k +: 8] <= 8'h00;
      else if (req_wr && req_be[k]) req_q[8*k +: 8] <= req_wdata[8*k +: 8];
  end

  wire req_bad = |(req_q & ~HOST_MASK);
  wire accept  = ok_wr && !ok_q && !req_bad;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ok_q  <= 1'b0;
      neg_q <= 64'h0;
    end else if (accept) begin
      ok_q  <= 1'b1;
      neg_q <= req_q;
    end

  wire is_on    = cmd_wr && (cmd_code == CMD_ACPI_ON);
  wire is_off   = cmd_wr && (cmd_code == CMD_ACPI_OFF);
  wire raise    = cmd_wr && !is_on && !is_off && smi_cmd_en;
  wire [NCPU-1:0] smi_d = !raise   ? '0 :
                          neg_q[0] ? '1 : (ONE << cmd_cpu);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      on_q  <= 1'b0;
      off_q <= 1'b0;
      smi_q <= '0;
    end else begin
      on_q  <= is_on;
      off_q <= is_off;
      smi_q <= smi_d;
    end

  assign host_mask      = HOST_MASK;
  assign req_word       = req_q;
  assign ok_flag        = ok_q;
  assign neg_feat       = neg_q;
  assign acpi_on_pulse  = on_q;
  assign acpi_off_pulse = off_q;
  assign smi_pulse      = smi_q;

endmodule

// File: rtl/smi_negotiator_chk.sv
module smi_negotiator_chk #(
  parameter int          NCPU      = 4,
  parameter logic [63:0] HOST_MASK = 64'h1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ok_wr,
  input logic            cmd_wr,
  input logic            smi_cmd_en,
  input logic            ok_flag,
  input logic [63:0]     neg_feat,
  input logic            acpi_on_pulse,
  input logic            acpi_off_pulse,
  input logic [NCPU-1:0] smi_pulse
);

  AST_OK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ok_flag |=> ok_flag); // R5
  AST_NEG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) ok_flag |=> $stable(neg_feat)); // R5
  AST_NEG_SUBSET: assert property (@(posedge clk) disable iff (!rst_n) (neg_feat & ~HOST_MASK) == 64'h0); // R4
  AST_OK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ok_flag) |-> $past(ok_wr)); // R3
  AST_SMI_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n) (|smi_pulse) |-> $past(cmd_wr && smi_cmd_en)); // R8
  AST_ON_NO_SMI: assert property (@(posedge clk) disable iff (!rst_n) acpi_on_pulse |-> (smi_pulse == '0)); // R6
  AST_OFF_NO_SMI: assert property (@(posedge clk) disable iff (!rst_n) acpi_off_pulse |-> (smi_pulse == '0) && !acpi_on_pulse); // R7
  AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n) ((|smi_pulse) && $past(neg_feat[0])) |-> (&smi_pulse)); // R9
  AST_SINGLE_ONE: assert property (@(posedge clk) disable iff (!rst_n) ((|smi_pulse) && !$past(neg_feat[0])) |-> ($countones(smi_pulse) == 1)); // R10

endmodule

bind smi_negotiator smi_negotiator_chk #(.NCPU(NCPU), .HOST_MASK(HOST_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .ok_wr(ok_wr), .cmd_wr(cmd_wr), .smi_cmd_en(smi_cmd_en),
  .ok_flag(ok_flag), .neg_feat(neg_feat), .acpi_on_pulse(acpi_on_pulse),
  .acpi_off_pulse(acpi_off_pulse), .smi_pulse(smi_pulse)
);

// File: tb/smi_negotiator_bench.sv
module smi_negotiator_bench;
  localparam int          NCPU = 4;
  localparam logic [63:0] MASK = 64'h8000_0000_0000_0011;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            req_wr = 1'b0;
  logic [7:0]      req_be = '0;
  logic [63:0]     req_wdata = '0;
  logic            ok_wr = 1'b0;
  logic            cmd_wr = 1'b0;
  logic [7:0]      cmd_code = '0;
  logic [1:0]      cmd_cpu = '0;
  logic            smi_cmd_en = 1'b0;
  logic [63:0]     host_mask, req_word, neg_feat;
  logic            ok_flag, acpi_on_pulse, acpi_off_pulse;
  logic [NCPU-1:0] smi_pulse;

  smi_negotiator #(.NCPU(NCPU), .HOST_MASK(MASK)) u_smi_negotiator (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_be(req_be), .req_wdata(req_wdata),
    .ok_wr(ok_wr), .cmd_wr(cmd_wr), .cmd_code(cmd_code), .cmd_cpu(cmd_cpu),
    .smi_cmd_en(smi_cmd_en), .host_mask(host_mask), .req_word(req_word),
    .ok_flag(ok_flag), .neg_feat(neg_feat), .acpi_on_pulse(acpi_on_pulse),
    .acpi_off_pulse(acpi_off_pulse), .smi_pulse(smi_pulse));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_req(input logic [7:0] be, input logic [63:0] d);
    @(negedge clk); req_wr = 1'b1; req_be = be; req_wdata = d;
    @(negedge clk); req_wr = 1'b0; req_be = '0;
  endtask

  task automatic validate();
    @(negedge clk); ok_wr = 1'b1;
    @(negedge clk); ok_wr = 1'b0;
  endtask

  task automatic command(input logic [7:0] c, input logic [1:0] cpu, input logic en);
    @(negedge clk); cmd_wr = 1'b1; cmd_code = c; cmd_cpu = cpu; smi_cmd_en = en;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  // {code, cpu, en, exp_on, exp_off, exp_smi}; negotiated bit 0 is clear here
  localparam logic [16:0] VEC [8] = '{
    {8'h02, 2'd0, 1'b1, 1'b1, 1'b0, 4'b0000},  // R6
    {8'h03, 2'd2, 1'b1, 1'b0, 1'b1, 4'b0000},  // R7
    {8'hB2, 2'd1, 1'b0, 1'b0, 1'b0, 4'b0000},  // R8
    {8'hB2, 2'd1, 1'b1, 1'b0, 1'b0, 4'b0010},  // R10
    {8'hB2, 2'd3, 1'b1, 1'b0, 1'b0, 4'b1000},  // R10
    {8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 4'b0001},  // R10
    {8'h02, 2'd3, 1'b0, 1'b1, 1'b0, 4'b0000},  // R6
    {8'h7F, 2'd2, 1'b1, 1'b0, 1'b0, 4'b0100}   // R10
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req", req_word, 64'h0);
    check("R1 ok", {63'h0, ok_flag}, 64'h0);
    check("R1 neg", neg_feat, 64'h0);
    check("R1 smi", {60'h0, smi_pulse}, 64'h0);
    check("R11 mask", host_mask, MASK);

    write_req(8'h80, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R2 top lane", req_word, 64'hFF00_0000_0000_0000);
    validate();
    check("R4 ok", {63'h0, ok_flag}, 64'h0);
    check("R4 neg", neg_feat, 64'h0);

    write_req(8'hFF, 64'h10);
    check("R2 full", req_word, 64'h10);
    validate();
    check("R3 ok", {63'h0, ok_flag}, 64'h1);
    check("R3 neg", neg_feat, 64'h10);

    write_req(8'hFF, 64'h11);
    validate();
    check("R5 ok", {63'h0, ok_flag}, 64'h1);
    check("R5 neg", neg_feat, 64'h10);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cmd_wr = 1'b1; cmd_code = VEC[i][16:9]; cmd_cpu = VEC[i][8:7]; smi_cmd_en = VEC[i][6];
      @(negedge clk);
      cmd_wr = 1'b0;
      check("R6 on", {63'h0, acpi_on_pulse}, {63'h0, VEC[i][5]});
      check("R7 off", {63'h0, acpi_off_pulse}, {63'h0, VEC[i][4]});
      check("R8/R10 smi", {60'h0, smi_pulse}, {60'h0, VEC[i][3:0]});
      @(negedge clk);
      check("R6/R7 pulse width", {62'h0, acpi_on_pulse, acpi_off_pulse}, 64'h0);
      check("R10 pulse width", {60'h0, smi_pulse}, 64'h0);
    end

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 held ok", {63'h0, ok_flag}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req after", req_word, 64'h0);
    check("R1 neg after", neg_feat, 64'h0);

    write_req(8'hFF, MASK);
    write_req(8'h01, 64'hAB);
    check("R2 low lane", req_word, 64'h8000_0000_0000_00AB);
    validate();
    check("R4 reject ab", {63'h0, ok_flag}, 64'h0);
    write_req(8'h01, 64'h11);
    validate();
    check("R3 bcast neg", neg_feat, MASK);

    command(8'hB2, 2'd2, 1'b1);
    check("R9 all cpus", {60'h0, smi_pulse}, 64'hF);
    command(8'hB2, 2'd2, 1'b0);
    check("R8 disabled", {60'h0, smi_pulse}, 64'h0);
    command(8'h03, 2'd1, 1'b1);
    check("R7 bcast no smi", {60'h0, smi_pulse}, 64'h0);
    check("R7 off pulse", {63'h0, acpi_off_pulse}, 64'h1);
    check("R11 mask end", host_mask, MASK);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule